// File: doc/BRIEF.md
# I/O-Read Idle Request Redirector

This block sits on a core's I/O read path. It inspects each I/O read and sorts it into one of two kinds. Most reads are ordinary port accesses. A read that lands in a small programmed address window is different: it is really a request to enter an idle state, and the block turns it into an internal wait-for-event request.

The window starts at a programmable base address and holds one slot per idle level. The first slot, at the base, selects the shallower level and maps to C3. The next slot, at base plus one, selects the deeper level and maps to C6. A maximum-level field limits how many slots are live.

A redirected request always has a zero substate and always has the break-on-interrupt flag set. With that flag set, a pending interrupt wakes the core even when interrupts are masked. Every read that is not redirected goes out unchanged on the pass-through strobe to the normal I/O path. Power sequencing after the request is not part of this block.

Top module: `io_idle_redirector`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `idle_req_valid` and `pass_valid` are both 0.
- R2: If `cfg_valid`=1, `cfg_max_level`>=2 and a read hits `rd_addr`==`cfg_base`, then one cycle later `idle_req_valid` pulses with `idle_req_state`=3 (C3).
- R3: If `cfg_valid`=1, `cfg_max_level`>=3 and a read hits `rd_addr`==`cfg_base`+1, then one cycle later `idle_req_valid` pulses with `idle_req_state`=6 (C6). The state field codes are C1=1, C3=3 and C6=6.
- R4: A level read whose level number (2 for the base, 3 for base+1) is greater than `cfg_max_level` is not redirected. It appears on `pass_valid` instead. A `cfg_max_level` of 0 or 1 traps nothing.
- R5: A read outside the window appears one cycle later on `pass_valid`, with `pass_addr` equal to the read address.
- R6: Every redirected request has `idle_req_sub`=0 and `idle_req_brk`=1.
- R7: While `cfg_valid`=0, every read passes through, whatever its address.
- R8: Each accepted read (`rd_valid`=1) produces, one cycle later, exactly one one-cycle pulse on either `idle_req_valid` or `pass_valid`. The two never assert together, and neither asserts without a read.
- R9: The base+1 slot is computed modulo 2^ADDR_W. With base 0xFFFF, a read at 0x0000 is the level-3 slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | I/O read strobe |
| rd_addr | input | ADDR_W | I/O read address |
| cfg_base | input | ADDR_W | Base address of the level window |
| cfg_max_level | input | 3 | Highest level number that is trapped |
| cfg_valid | input | 1 | Window configuration is valid |
| idle_req_valid | output | 1 | Redirected idle request pulse |
| idle_req_state | output | 3 | Target C-state code |
| idle_req_sub | output | SUB_W | Substate, always zero |
| idle_req_brk | output | 1 | Break on masked interrupt |
| pass_valid | output | 1 | Pass-through read pulse |
| pass_addr | output | ADDR_W | Pass-through read address |

## Verification
The bench drives reads at the base, at base+1, just below the base and just above the window. For each address it sweeps `cfg_max_level` across 0 to 3 and toggles `cfg_valid`. These patterns separate the slot comparison from the range gate and from the configuration gate: the same address has to flip between redirect and pass-through as only the limit or the valid bit changes. Further patterns cover back-to-back reads, idle cycles with no read, and a base at the top of the address space to show the wrap. Reset is applied in the middle of a read to show that no pulse survives it.

// File: rtl/idle_redir_pkg.sv
// Shared types for the I/O-read idle redirector.
// Assumes at most two trap levels (shallow, deep) in this release.
package idle_redir_pkg;

    // C-state codes carried on the 3-bit state field.
    typedef enum logic [2:0] {
        CST_C0 = 3'd0,
        CST_C1 = 3'd1,
        CST_C3 = 3'd3,
        CST_C6 = 3'd6
    } cstate_e;

    // Level number of the first window slot (the slot at the base address).
    localparam int unsigned FIRST_LEVEL = 2;

    // Map a window slot index to its target C-state.
    function automatic cstate_e slot_to_cstate(input int unsigned slot);
        case (slot)
            0:       return CST_C3;
            1:       return CST_C6;
            default: return CST_C1;
        endcase
    endfunction

endpackage

// File: rtl/idle_window_decode.sv
// Window decoder: compares a read address with each level slot of the
// programmed window and gates each slot with the range limit and the
// configuration-valid bit. Purely combinational.
// Assumes slot i sits at base+i (modulo 2^ADDR_W) and has level FIRST_LEVEL+i.
module idle_window_decode
    import idle_redir_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned NUM_SLOTS = 2
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [ADDR_W-1:0]    base,
    input  logic [2:0]           max_level,
    input  logic                 cfg_valid,
    output logic [NUM_SLOTS-1:0] slot_hit
);

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            localparam logic [ADDR_W-1:0] OFFSET = ADDR_W'(s);
            localparam logic [2:0]        LEVEL  = 3'(FIRST_LEVEL + s);
            logic [ADDR_W-1:0] slot_addr;
            logic              in_range;

            // Slot address wraps within the address width.
            always_comb slot_addr = base + OFFSET;

            // A slot is live only if its level does not exceed the limit.
            always_comb in_range = (LEVEL <= max_level);

            // Hit when configured, in range and the address matches.
            always_comb slot_hit[s] = cfg_valid && in_range && (addr == slot_addr);
        end
    endgenerate

endmodule

// File: rtl/idle_code_map.sv
// Code mapper: turns a slot-hit vector into one redirect flag and the
// target C-state code. Lowest slot wins, although slots never overlap
// while NUM_SLOTS is at most 2^ADDR_W.
module idle_code_map
    import idle_redir_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 2
) (
    input  logic [NUM_SLOTS-1:0] slot_hit,
    output logic                 redirect,
    output cstate_e              state
);

    // Priority pick of the first hitting slot and its code.
    always_comb begin
        redirect = 1'b0;
        state    = CST_C0;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (slot_hit[s]) begin
                redirect = 1'b1;
                state    = slot_to_cstate(s);
            end
        end
    end

    // R3: a hit in the deep slot alone carries the C6 code.
    a_r3_deep_code: assert property (@(slot_hit) (slot_hit == NUM_SLOTS'(2)) |-> (state == CST_C6))
        else $error("deep slot not mapped to C6");

endmodule

// File: rtl/idle_redir_out.sv
// Output stage: registers one outcome per accepted read. A redirect raises
// the idle request with a zero substate and the break flag; anything else
// raises the pass-through strobe with the original address. Both strobes
// are one-cycle pulses.
module idle_redir_out
    import idle_redir_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned SUB_W      = 4,
    parameter bit          BRK_ON_IRQ = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              redirect,
    input  cstate_e           state_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              idle_valid,
    output logic [2:0]        idle_state,
    output logic [SUB_W-1:0]  idle_sub,
    output logic              idle_brk,
    output logic              pass_valid,
    output logic [ADDR_W-1:0] pass_addr
);

    // Registers the outcome of the current read, or clears both strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_valid <= 1'b0;
            idle_state <= CST_C0;
            idle_sub   <= '0;
            idle_brk   <= 1'b0;
            pass_valid <= 1'b0;
            pass_addr  <= '0;
        end else begin
            idle_valid <= accept && redirect;
            pass_valid <= accept && !redirect;
            if (accept && redirect) begin
                idle_state <= state_in;
                idle_sub   <= '0;
                idle_brk   <= BRK_ON_IRQ;
            end
            if (accept && !redirect) begin
                pass_addr <= addr_in;
            end
        end
    end

    // R8: the two strobes never assert together.
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(idle_valid && pass_valid))
        else $error("redirect and pass-through together");

    // R5: a pass-through carries the address of the read that caused it.
    a_r5_pass_addr: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(accept) && !$past(redirect)) |-> (pass_addr == $past(addr_in)))
        else $error("pass-through address mismatch");

endmodule

// File: rtl/io_idle_redirector.sv
// Top level: sorts each I/O read into a redirected idle request or a
// pass-through, with one cycle of latency.
// Assumes the configuration inputs are stable around a read; a read is
// judged against the configuration present in its own cycle.
module io_idle_redirector
    import idle_redir_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned SUB_W      = 4,
    parameter int unsigned NUM_SLOTS  = 2,
    parameter bit          BRK_ON_IRQ = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [2:0]        cfg_max_level,
    input  logic              cfg_valid,
    output logic              idle_req_valid,
    output logic [2:0]        idle_req_state,
    output logic [SUB_W-1:0]  idle_req_sub,
    output logic              idle_req_brk,
    output logic              pass_valid,
    output logic [ADDR_W-1:0] pass_addr
);

    logic [NUM_SLOTS-1:0] slot_hit;
    logic                 redirect;
    cstate_e              req_state;

    idle_window_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_decode (
        .addr      (rd_addr),
        .base      (cfg_base),
        .max_level (cfg_max_level),
        .cfg_valid (cfg_valid),
        .slot_hit  (slot_hit)
    );

    idle_code_map #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_map (
        .slot_hit  (slot_hit),
        .redirect  (redirect),
        .state     (req_state)
    );

    idle_redir_out #(
        .ADDR_W     (ADDR_W),
        .SUB_W      (SUB_W),
        .BRK_ON_IRQ (BRK_ON_IRQ)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (rd_valid),
        .redirect   (redirect),
        .state_in   (req_state),
        .addr_in    (rd_addr),
        .idle_valid (idle_req_valid),
        .idle_state (idle_req_state),
        .idle_sub   (idle_req_sub),
        .idle_brk   (idle_req_brk),
        .pass_valid (pass_valid),
        .pass_addr  (pass_addr)
    );

    // R8: every accepted read yields an outcome on the next cycle.
    a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_valid)) |-> (idle_req_valid || pass_valid))
        else $error("read produced no outcome");

    // R8: no outcome appears without a read.
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_valid) |-> !(idle_req_valid || pass_valid))
        else $error("outcome without a read");

    // R7: an unconfigured window never redirects.
    a_r7_unconfigured: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_valid) && !$past(cfg_valid)) |-> pass_valid)
        else $error("redirect while unconfigured");

    // R6: a redirected request has a zero substate and the break flag.
    a_r6_attrs: assert property (@(posedge clk) disable iff (!rst_n)
        idle_req_valid |-> (idle_req_sub == '0 && idle_req_brk))
        else $error("bad redirect attributes");

    // R2: a base-address read under limit >= 2 becomes a C3 request.
    a_r2_base_c3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_valid) && $past(cfg_valid) && $past(cfg_max_level) >= 3'd2
         && $past(rd_addr) == $past(cfg_base)) |-> (idle_req_valid && idle_req_state == 3'd3))
        else $error("base read not redirected to C3");

endmodule

// File: tb/io_idle_redirector_test.sv
module io_idle_redirector_test;

    localparam int unsigned ADDR_W = 16;
    localparam int unsigned SUB_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_valid = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [2:0]        cfg_max_level = '0;
    logic              cfg_valid = 1'b0;
    logic              idle_req_valid;
    logic [2:0]        idle_req_state;
    logic [SUB_W-1:0]  idle_req_sub;
    logic              idle_req_brk;
    logic              pass_valid;
    logic [ADDR_W-1:0] pass_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    io_idle_redirector #(.ADDR_W(ADDR_W), .SUB_W(SUB_W)) uut (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .cfg_base(cfg_base), .cfg_max_level(cfg_max_level), .cfg_valid(cfg_valid),
        .idle_req_valid(idle_req_valid), .idle_req_state(idle_req_state),
        .idle_req_sub(idle_req_sub), .idle_req_brk(idle_req_brk),
        .pass_valid(pass_valid), .pass_addr(pass_addr)
    );

    // Vector: configuration, address, expected redirect flag and state.
    typedef struct packed {
        logic              cv;
        logic [2:0]        lim;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] addr;
        logic              redir;
        logic [2:0]        st;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd3, 16'h0414, 16'h0414, 1'b1, 3'd3},  // R2 base, full range
        '{1'b1, 3'd2, 16'h0414, 16'h0414, 1'b1, 3'd3},  // R2 base, level-2 only
        '{1'b1, 3'd3, 16'h0414, 16'h0415, 1'b1, 3'd6},  // R3 base+1
        '{1'b1, 3'd7, 16'h0414, 16'h0415, 1'b1, 3'd6},  // R3 large limit
        '{1'b1, 3'd2, 16'h0414, 16'h0415, 1'b0, 3'd0},  // R4 level 3 beyond limit
        '{1'b1, 3'd1, 16'h0414, 16'h0414, 1'b0, 3'd0},  // R4 limit 1 traps nothing
        '{1'b1, 3'd0, 16'h0414, 16'h0415, 1'b0, 3'd0},  // R4 limit 0 traps nothing
        '{1'b1, 3'd3, 16'h0414, 16'h0413, 1'b0, 3'd0},  // R5 just below window
        '{1'b1, 3'd3, 16'h0414, 16'h0416, 1'b0, 3'd0},  // R5 just above window
        '{1'b1, 3'd3, 16'h0414, 16'h0080, 1'b0, 3'd0},  // R5 unrelated port
        '{1'b0, 3'd3, 16'h0414, 16'h0414, 1'b0, 3'd0},  // R7 unconfigured base
        '{1'b0, 3'd3, 16'h0414, 16'h0415, 1'b0, 3'd0},  // R7 unconfigured base+1
        '{1'b1, 3'd3, 16'hFFFF, 16'h0000, 1'b1, 3'd6},  // R9 wrap
        '{1'b1, 3'd3, 16'hFFFF, 16'hFFFF, 1'b1, 3'd3}   // R9 base at top
    };

    // Records one comparison.
    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drives one read at the falling edge; outputs are valid one falling edge later.
    task automatic do_read(input logic cv, input logic [2:0] lim,
                           input logic [ADDR_W-1:0] base, input logic [ADDR_W-1:0] addr);
        cfg_valid = cv; cfg_max_level = lim; cfg_base = base;
        rd_addr = addr; rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    // Checks one read's outcome against the expected kind.
    task automatic expect_out(input string req, input logic redir, input logic [2:0] st,
                              input logic [ADDR_W-1:0] addr);
        check(req, "idle_req_valid", int'(idle_req_valid), int'(redir));
        check(req, "pass_valid", int'(pass_valid), int'(!redir));
        if (redir) begin
            check(req, "state", int'(idle_req_state), int'(st));
            check("R6", "sub", int'(idle_req_sub), 0);
            check("R6", "brk", int'(idle_req_brk), 1);
        end else begin
            check(req, "pass_addr", int'(pass_addr), int'(addr));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "idle_req_valid in reset", int'(idle_req_valid), 0);
        check("R1", "pass_valid in reset", int'(pass_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle after release", int'(idle_req_valid), 0);
        check("R1", "pass after release", int'(pass_valid), 0);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            do_read(VECS[i].cv, VECS[i].lim, VECS[i].base, VECS[i].addr);
            expect_out(VECS[i].redir ? (VECS[i].st == 3'd6 ? "R3" : "R2")
                                     : (VECS[i].cv ? "R4/R5" : "R7"),
                       VECS[i].redir, VECS[i].st, VECS[i].addr);
            @(negedge clk);
            check("R8", "idle pulse ends", int'(idle_req_valid), 0);
            check("R8", "pass pulse ends", int'(pass_valid), 0);
        end

        // R8: back-to-back reads, each with its own outcome.
        cfg_valid = 1'b1; cfg_max_level = 3'd3; cfg_base = 16'h0500;
        rd_valid = 1'b1; rd_addr = 16'h0500;
        @(negedge clk);
        expect_out("R8", 1'b1, 3'd3, 16'h0500);
        rd_addr = 16'h0042;
        @(negedge clk);
        expect_out("R8", 1'b0, 3'd0, 16'h0042);
        rd_addr = 16'h0501;
        @(negedge clk);
        expect_out("R8", 1'b1, 3'd6, 16'h0501);
        rd_valid = 1'b0;
        @(negedge clk);
        check("R8", "no read no idle", int'(idle_req_valid), 0);
        check("R8", "no read no pass", int'(pass_valid), 0);

        // R8: window address without strobe yields nothing.
        rd_addr = 16'h0500;
        repeat (2) @(negedge clk);
        check("R8", "idle without strobe", int'(idle_req_valid), 0);
        check("R8", "pass without strobe", int'(pass_valid), 0);

        // R1: reset during a read suppresses its outcome.
        rd_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        rd_valid = 1'b0;
        check("R1", "idle after reset read", int'(idle_req_valid), 0);
        check("R1", "pass after reset read", int'(pass_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(1'b1, 3'd3, 16'h0500, 16'h0501);
        expect_out("R3", 1'b1, 3'd6, 16'h0501);

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int n = 0; n < 5000 && !done; n++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule